// File: doc/BRIEF.md
# Supply voltage monitor controller

This block is the digital half of a supply-voltage monitor. An analog comparator outside the block raises `cmp_low` while the supply sits below its detection threshold. The block turns that signal into either an interrupt request or an internal reset request. One byte-wide control/status register at a fixed address selects which of the two it produces. The register holds an enable bit, a mode bit and a read-only undervoltage flag.

The comparator output is asynchronous, so it passes through a two-stage synchronizer. After each enable, the flag is also held low for a programmable number of clock cycles while the comparator settles. The default settle count covers 0.2 ms at a 50 MHz clock. In reset mode, an undervoltage condition produces a reset-request pulse of fixed width. It also sets a sticky source indicator, which tells the chip's reset controller that the reset came from the monitor.

The block has two reset inputs:
- `ext_rst_n` covers every reset source except the monitor. It clears all state, including the register.
- `rst_n` is the chip-wide reset, which also follows the monitor's own request. It restarts only the synchronizer and the settle timer, so the register survives.

Top module: `vmon_ctrl`

## Requirements
- R1: The register answers only at address `REG_ADDR` (default FF50h). A write to any other address changes nothing, and a read at any other address returns 00h.
- R2: Read data is {enable, 5'b00000, mode, flag}, with enable in bit 7, mode in bit 1 and the flag in bit 0. Bits 6 to 2 always read 0. Write data in bits 6 to 2 and bit 0 is ignored.
- R3: On a write, a register bit changes only when its `bit_we` bit is 1. A full-byte write sets `bit_we` to FFh. A single-bit write sets only the matching bit.
- R4: While `ext_rst_n` is low, the register reads 00h, and `irq`, `rst_req` and `rst_src` are 0.
- R5: The flag is 1 only when enable is 1, the settle time has run out and the synchronized comparator input is 1. A change on `cmp_low` reaches the flag on the second rising clock edge after it.
- R6: After the write edge that sets enable, the flag stays 0 through the next `SETTLE_CYC`-1 edges. It may first become 1 after edge `SETTLE_CYC`. Each new enable restarts this count.
- R7: With enable 1 and mode 0, `irq` equals the flag, and `rst_req` stays 0.
- R8: With enable 1 and mode 1, `irq` stays 0. A set flag starts a `rst_req` pulse on the next clock edge, and the pulse lasts exactly `RST_PULSE_CYC` cycles.
- R9: `rst_src` goes to 1 when a reset pulse starts and stays 1 until `ext_rst_n` is asserted.
- R10: While `rst_n` is low and `ext_rst_n` is high, the enable and mode bits keep their values and the flag reads 0. The settle count starts again once `rst_n` is released.
- R11: Clearing enable, by a byte write of 00h or a single-bit write of bit 7, forces the flag and `irq` to 0 from the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Asynchronous active-low reset from every source except the monitor |
| rst_n | input | 1 | Asynchronous active-low chip reset, including the monitor's own |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| bit_we | input | 8 | Per-bit write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the address |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| irq | output | 1 | Level interrupt request |
| rst_req | output | 1 | Internal reset request pulse |
| rst_src | output | 1 | Sticky indicator that the monitor requested a reset |

## Verification
Three internal faults show up quickly at the ports:
- A stuck or wrongly loaded enable or mode bit shows in `rdata` on the very next read.
- A settle counter that is off by one moves the first cycle in which bit 0 and `irq` rise. This is visible exactly at edge `SETTLE_CYC` after the enable write.
- A synchronizer with the wrong depth shifts the `irq` response to a comparator change by one cycle.

Two faults appear later:
- A reset pulse counter that is loaded wrongly changes the measured `rst_req` width, visible within one pulse.
- A register that is wrongly cleared by `rst_n` shows as 00h on the first read after a monitor-caused reset.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BIT_EN   = 7;
    localparam int unsigned BIT_MODE = 1;
    localparam int unsigned BIT_FLAG = 0;

    typedef struct packed {
        logic en;
        logic mode;
    } vmon_ctrl_t;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/vmon_settle.sv
module vmon_settle #(
    parameter int unsigned SETTLE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic settled
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)              cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled = (cnt_q == LIM);
endmodule

// File: rtl/vmon_rst_pulse.sv
module vmon_rst_pulse #(
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic trig,
    output logic req,
    output logic src
);
    localparam int unsigned PW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          src;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (trig) begin
            st_d.cnt = PW'(PULSE_CYC);
            st_d.src = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign req = (st_q.cnt != '0);
    assign src = st_q.src;
endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
    import vmon_pkg::*;
#(
    parameter int unsigned     ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 16'hFF50,
    parameter int unsigned     SYNC_STAGES   = 2,
    parameter int unsigned     SETTLE_CYC    = 10000,
    parameter int unsigned     RST_PULSE_CYC = 16
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        bit_we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              cmp_low,
    output logic              irq,
    output logic              rst_req,
    output logic              rst_src
);
    vmon_ctrl_t ctrl_d, ctrl_q;
    logic       hit, cmp_s, settled, flag, trig;

    logic unused_bits;
    assign unused_bits = ^{wdata[6:2], wdata[BIT_FLAG], bit_we[6:2], bit_we[BIT_FLAG]};

    vmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst_n (rst_n),
        .din (cmp_low),
        .dout (cmp_s)
    );

    vmon_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk (clk),
        .rst_n (rst_n),
        .en (ctrl_q.en),
        .settled (settled)
    );

    vmon_rst_pulse #(.PULSE_CYC(RST_PULSE_CYC)) pulse_i (
        .clk (clk),
        .ext_rst_n (ext_rst_n),
        .trig (trig),
        .req (rst_req),
        .src (rst_src)
    );

    assign hit = (addr == REG_ADDR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && hit) begin
            if (bit_we[BIT_EN])   ctrl_d.en   = wdata[BIT_EN];
            if (bit_we[BIT_MODE]) ctrl_d.mode = wdata[BIT_MODE];
        end
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) ctrl_q <= '0;
        else            ctrl_q <= ctrl_d;
    end

    assign flag = ctrl_q.en & settled & cmp_s;
    assign irq  = flag & ~ctrl_q.mode;
    assign trig = flag & ctrl_q.mode;

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[BIT_EN]   = ctrl_q.en;
            rdata[BIT_MODE] = ctrl_q.mode;
            rdata[BIT_FLAG] = flag;
        end
    end
endmodule

// File: rtl/vmon_ctrl_chk.sv
module vmon_ctrl_chk #(
    parameter int unsigned PULSE_CYC = 16
) (
    input logic       clk,
    input logic       ext_rst_n,
    input logic       rst_n,
    input logic       wr_en,
    input logic       en,
    input logic       mode,
    input logic       settled,
    input logic       irq,
    input logic       rst_req,
    input logic       rst_src,
    input logic [7:0] rdata
);
    localparam int unsigned HW = $clog2(PULSE_CYC + 2);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)   hi_cnt <= '0;
        else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    // R2
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        rdata[6:2] == 5'b0);

    // R6
    settle_gate_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !settled |-> !irq && !rst_req || rst_req);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(rst_req) |-> en && mode);

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(rst_req) |-> hi_cnt == HW'(PULSE_CYC));

    // R8
    pulse_max_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        rst_req |-> hi_cnt < HW'(PULSE_CYC));

    // R9
    src_sticky_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        rst_req || $past(rst_src) |-> rst_src);

    // R10
    survive_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!rst_n && !wr_en) |=> $stable({en, mode}));
endmodule

bind vmon_ctrl vmon_ctrl_chk #(.PULSE_CYC(RST_PULSE_CYC)) chk_i (
    .clk (clk),
    .ext_rst_n (ext_rst_n),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .en (ctrl_q.en),
    .mode (ctrl_q.mode),
    .settled (settled),
    .irq (irq),
    .rst_req (rst_req),
    .rst_src (rst_src),
    .rdata (rdata)
);

// File: tb/vmon_ctrl_tb.sv
module vmon_ctrl_tb_top;
    localparam int CLK_P  = 10;
    localparam int SETTLE = 12;
    localparam int PULSE  = 5;
    localparam logic [15:0] RA = 16'hFF50;

    logic        clk = 1'b0;
    logic        ext_rst_n, rst_n, wr_en, cmp_low;
    logic [15:0] addr;
    logic [7:0]  bit_we, wdata, rdata;
    logic        irq, rst_req, rst_src;

    int n_chk = 0;
    int n_fail = 0;
    bit m_en, m_mode;

    always #(CLK_P/2) clk = ~clk;

    vmon_ctrl #(
        .ADDR_W(16), .REG_ADDR(RA), .SYNC_STAGES(2),
        .SETTLE_CYC(SETTLE), .RST_PULSE_CYC(PULSE)
    ) dut_i (
        .clk(clk), .ext_rst_n(ext_rst_n), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .bit_we(bit_we), .wdata(wdata), .rdata(rdata),
        .cmp_low(cmp_low), .irq(irq), .rst_req(rst_req), .rst_src(rst_src)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] we, logic [7:0] d);
        addr = a; wr_en = 1'b1; bit_we = we; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = RA;
    endtask

    function automatic logic [7:0] exp_rd(bit e, bit m, bit c);
        return {e, 5'b0, m, e & c};
    endfunction

    function automatic bit exp_irq(bit e, bit m, bit c);
        return e & ~m & c;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        ext_rst_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; cmp_low = 1'b0;
        addr = RA; bit_we = 8'h00; wdata = 8'h00;
        tick(3);
        ext_rst_n = 1'b1; rst_n = 1'b1;
        tick(1);
        // R4 reset state
        chk("R4 rdata", rdata, 8'h00);
        chk("R4 irq", {7'b0, irq}, 8'h00);
        chk("R4 rst_req", {7'b0, rst_req}, 8'h00);
        chk("R4 rst_src", {7'b0, rst_src}, 8'h00);

        // R2 reserved and read-only bits, R3 full byte
        wr(RA, 8'hFF, 8'hFF);
        chk("R2 R3 full write", rdata, 8'h82);
        wr(RA, 8'hFF, 8'h00);
        chk("R11 byte clear", rdata, 8'h00);

        // R1 address decode
        wr(16'hFF51, 8'hFF, 8'h80);
        chk("R1 foreign write", rdata, 8'h00);
        wr(RA, 8'hFF, 8'h80);
        addr = 16'h0050;
        tick(1);
        chk("R1 foreign read", rdata, 8'h00);
        addr = RA;

        // R3 single-bit writes
        wr(RA, 8'h02, 8'hFF);
        chk("R3 set mode only", rdata, 8'h82);
        wr(RA, 8'h02, 8'h00);
        chk("R3 clear mode only", rdata, 8'h80);
        wr(RA, 8'hFF, 8'h00);

        // R6 settle boundary, R7 irq
        cmp_low = 1'b1;
        tick(4);
        wr(RA, 8'hFF, 8'h80);
        tick(SETTLE - 1);
        chk("R6 before settle", rdata, 8'h80);
        chk("R6 irq before settle", {7'b0, irq}, 8'h00);
        tick(1);
        chk("R6 after settle", rdata, 8'h81);
        chk("R7 irq follows flag", {7'b0, irq}, 8'h01);

        // R5 two-stage latency
        cmp_low = 1'b0;
        tick(1);
        chk("R5 one edge", {7'b0, irq}, 8'h01);
        tick(1);
        chk("R5 two edges", {7'b0, irq}, 8'h00);
        cmp_low = 1'b1;
        tick(2);
        chk("R5 rise", {7'b0, irq}, 8'h01);

        // R11 single-bit disable and R6 restart
        wr(RA, 8'h80, 8'h00);
        chk("R11 bit clear rdata", rdata, 8'h00);
        chk("R11 bit clear irq", {7'b0, irq}, 8'h00);
        wr(RA, 8'h80, 8'h80);
        tick(SETTLE - 1);
        chk("R6 restart hold", {7'b0, irq}, 8'h00);
        tick(1);
        chk("R6 restart release", {7'b0, irq}, 8'h01);
        wr(RA, 8'hFF, 8'h00);
        chk("R11 byte stop irq", {7'b0, irq}, 8'h00);

        // R8 reset mode pulse, R9 source
        tick(2);
        wr(RA, 8'hFF, 8'h82);
        tick(SETTLE);
        chk("R8 flag in reset mode", rdata, 8'h83);
        chk("R8 no irq", {7'b0, irq}, 8'h00);
        chk("R8 not yet", {7'b0, rst_req}, 8'h00);
        tick(1);
        chk("R8 pulse start", {7'b0, rst_req}, 8'h01);
        chk("R9 src set", {7'b0, rst_src}, 8'h01);
        tick(PULSE - 1);
        chk("R8 pulse last cycle", {7'b0, rst_req}, 8'h01);
        tick(1);
        chk("R8 pulse end", {7'b0, rst_req}, 8'h00);

        // R10 monitor-caused reset keeps the register
        cmp_low = 1'b0;
        rst_n = 1'b0;
        tick(3);
        chk("R10 kept during reset", rdata, 8'h82);
        rst_n = 1'b1;
        tick(SETTLE + PULSE + 4);
        chk("R10 kept after reset", rdata, 8'h82);
        chk("R10 no new pulse", {7'b0, rst_req}, 8'h00);
        chk("R9 sticky", {7'b0, rst_src}, 8'h01);

        // R4 general reset clears everything
        ext_rst_n = 1'b0;
        tick(2);
        chk("R4 during general reset", rdata, 8'h00);
        ext_rst_n = 1'b1;
        tick(1);
        chk("R4 after general reset", rdata, 8'h00);
        chk("R4 src cleared", {7'b0, rst_src}, 8'h00);

        // random phase
        m_en = 1'b0; m_mode = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] we_r, d_r;
            bit old_rm, c;
            we_r = ($urandom % 2) ? 8'hFF : 8'($urandom);
            d_r  = 8'($urandom);
            old_rm = m_en & m_mode;
            if (we_r[7]) m_en = d_r[7];
            if (we_r[1]) m_mode = d_r[1];
            c = 1'($urandom);
            if (old_rm || (m_en && m_mode)) c = 1'b0;
            if (!c) begin
                cmp_low = 1'b0;
                tick(3);
            end
            wr(RA, we_r, d_r);
            cmp_low = c;
            tick(SETTLE + 4);
            chk("R2 R3 R7 random rdata", rdata, exp_rd(m_en, m_mode, c));
            chk("R7 random irq", {7'b0, irq}, {7'b0, exp_irq(m_en, m_mode, c)});
            chk("R8 random no pulse", {7'b0, rst_req}, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule